// File: doc/BRIEF.md
# Eight-Pin Port Expander Core

This core is the register and pin logic of an eight-pin general-purpose I/O expander that sits behind a byte-level two-wire target front end. The front end hands the core three things: a bus event strobe that marks any start, repeated start or stop condition; received bytes on a valid/ready stream; and a read request that the core answers in the same cycle. Inside are four byte-wide registers: sampled input, output latch, read polarity and pin direction. A single pointer register selects which of them a write or a read reaches.

Each pin behaves like an open-drain line with a pull-up. The pin is pulled low only when its direction bit and its output bit are both 0. In every other case the pin floats high unless the external device holds it low. The external levels arrive asynchronously and pass through a flop synchroniser before they are used. The resolved level of each pin is also driven out directly on a per-pin level output, without polarity inversion, for use as a wake or interrupt source.

Received-byte stream rules: a byte moves on a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` is high on every cycle except a cycle where `bus_evt` is high. A byte offered during an event is not taken, and the sender must hold it or drop it. The core never stalls the stream for any other reason.

Top module: `pin_expander`

## Requirements
- R1: After reset, the output and direction registers read 0xFF, polarity reads 0x00, the input register reads 0xFF, `pin_level` is 0xFF and the pointer is 0.
- R2: The first byte accepted after reset or after a bus event loads the pointer. Only pointer bits [1:0] select a register (0 input, 1 output, 2 polarity, 3 direction), and the upper bits are ignored.
- R3: Every later byte accepted in the same transaction is written to the selected register, and the pointer does not advance.
- R4: A bus event clears the byte count, so the next accepted byte is a pointer. `rx_ready` is low during the event cycle, and a byte offered in that cycle is not consumed.
- R5: While `rd_req` is high, `rd_data` returns the selected register in the same cycle. For the input register it returns input XOR polarity. The other registers return their stored value. `rd_data` is 0 when `rd_req` is low.
- R6: A byte written with the pointer selecting the input register changes no register and no output.
- R7: For each pin, drive = direction bit OR output bit. Drive 0 makes the input bit 0. Drive 1 makes the input bit equal to the synchronised external level.
- R8: A register write is visible on `rd_data` in the cycle after its accepting edge. The recomputed input bits appear one clock later. An external level change reaches `pin_level` on the third rising edge after it is applied.
- R9: `pin_level` equals the input register bits and is not affected by polarity.
- R10: A polarity write does not change `pin_level`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_evt | input | 1 | Start, repeated start or stop strobe |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Core accepts the byte (low during an event) |
| rx_data | input | 8 | Received byte |
| rd_req | input | 1 | Read byte request |
| rd_data | output | 8 | Read byte, valid in the cycle of `rd_req` |
| ext_level | input | 8 | Asynchronous external level per pin, 1 = released |
| pin_level | output | 8 | Resolved level per pin |

## Verification
The hardest case to reach is a byte that collides with a bus event. The stimulus offers a pointer-like byte in the same cycle as the event and then sends the real pointer. A read-back then shows which of the two was taken as the pointer. A second difficult case is the gap between a register write and the recomputed pin level. The bench samples `rd_data` and `pin_level` in the single cycle after the write, where the register shows the new value and the pin still shows the old one. A third case is the synchroniser delay: an external level change is sampled after two edges and again after three.

// File: rtl/pin_expander_pkg.sv
package pin_expander_pkg;
  localparam int unsigned PINS = 8;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_INPUT  = 2'd0,
    SEL_OUTPUT = 2'd1,
    SEL_POLAR  = 2'd2,
    SEL_DIR    = 2'd3
  } reg_sel_e;

  localparam logic [PINS-1:0] RST_OUTPUT = '1;
  localparam logic [PINS-1:0] RST_POLAR  = '0;
  localparam logic [PINS-1:0] RST_DIR    = '1;
  localparam logic [PINS-1:0] RST_INPUT  = '1;
  localparam logic [PINS-1:0] RST_EXT    = '1;
endpackage

// File: rtl/pin_expander_sync.sv
module pin_expander_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pin_expander_regs.sv
module pin_expander_regs
  import pin_expander_pkg::*;
#(
  parameter int unsigned DW = PINS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_evt,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  output logic [DW-1:0] ptr_q,
  output logic          have_ptr_q,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] pol_q,
  output logic [DW-1:0] dir_q
);
  logic     take;
  reg_sel_e sel;

  assign rx_ready = ~bus_evt;
  assign take     = rx_valid & rx_ready;
  assign sel      = reg_sel_e'(ptr_q[SEL_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      have_ptr_q <= 1'b0;
    end else if (bus_evt) begin
      have_ptr_q <= 1'b0;
    end else if (take && !have_ptr_q) begin
      ptr_q      <= rx_data;
      have_ptr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= RST_OUTPUT;
      pol_q <= RST_POLAR;
      dir_q <= RST_DIR;
    end else if (take && have_ptr_q) begin
      case (sel)
        SEL_OUTPUT: out_q <= rx_data;
        SEL_POLAR:  pol_q <= rx_data;
        SEL_DIR:    dir_q <= rx_data;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/pin_expander_resolve.sv
module pin_expander_resolve
  import pin_expander_pkg::*;
#(
  parameter int unsigned NPIN = PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] out_q,
  input  logic [NPIN-1:0] dir_q,
  input  logic [NPIN-1:0] ext_sync,
  output logic [NPIN-1:0] in_q
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic drive;
    logic level_nxt;
    assign drive     = dir_q[p] | out_q[p];
    assign level_nxt = drive ? ext_sync[p] : 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    in_q[p] <= RST_INPUT[p];
      else if (level_nxt != in_q[p]) in_q[p] <= level_nxt;
    end
  end
endmodule

// File: rtl/pin_expander.sv
module pin_expander
  import pin_expander_pkg::*;
#(
  parameter int unsigned NPIN        = PINS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_evt,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic [NPIN-1:0] rx_data,
  input  logic            rd_req,
  output logic [NPIN-1:0] rd_data,
  input  logic [NPIN-1:0] ext_level,
  output logic [NPIN-1:0] pin_level
);
  logic [NPIN-1:0] ptr_reg;
  logic            have_ptr;
  logic [NPIN-1:0] out_reg;
  logic [NPIN-1:0] pol_reg;
  logic [NPIN-1:0] dir_reg;
  logic [NPIN-1:0] in_reg;
  logic [NPIN-1:0] ext_sync;
  logic [NPIN-1:0] sel_val;

  pin_expander_sync #(
    .WIDTH  (NPIN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(RST_EXT)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(ext_level),
    .sync_out(ext_sync)
  );

  pin_expander_regs #(.DW(NPIN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_evt   (bus_evt),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rx_data   (rx_data),
    .ptr_q     (ptr_reg),
    .have_ptr_q(have_ptr),
    .out_q     (out_reg),
    .pol_q     (pol_reg),
    .dir_q     (dir_reg)
  );

  pin_expander_resolve #(.NPIN(NPIN)) u_resolve (
    .clk     (clk),
    .rst_n   (rst_n),
    .out_q   (out_reg),
    .dir_q   (dir_reg),
    .ext_sync(ext_sync),
    .in_q    (in_reg)
  );

  always_comb begin
    case (reg_sel_e'(ptr_reg[SEL_W-1:0]))
      SEL_INPUT:  sel_val = in_reg ^ pol_reg;
      SEL_OUTPUT: sel_val = out_reg;
      SEL_POLAR:  sel_val = pol_reg;
      default:    sel_val = dir_reg;
    endcase
  end

  assign rd_data   = rd_req ? sel_val : '0;
  assign pin_level = in_reg;
endmodule

// File: rtl/pin_expander_chk.sv
module pin_expander_chk #(
  parameter int unsigned NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_evt,
  input logic            rx_valid,
  input logic            rx_ready,
  input logic            rd_req,
  input logic [NPIN-1:0] rd_data,
  input logic [NPIN-1:0] pin_level,
  input logic [NPIN-1:0] ptr_reg,
  input logic            have_ptr,
  input logic [NPIN-1:0] out_reg,
  input logic [NPIN-1:0] pol_reg,
  input logic [NPIN-1:0] dir_reg
);
  assert_evt_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_evt |-> !rx_ready);

  assert_evt_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_evt |=> !have_ptr);

  assert_ptr_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && have_ptr) |=> $stable(ptr_reg));

  assert_input_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && have_ptr && ptr_reg[1:0] == 2'd0)
      |=> ($stable(out_reg) && $stable(pol_reg) && $stable(dir_reg)));

  assert_pulled_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> ((pin_level & ~$past(out_reg | dir_reg)) == '0));

  assert_read_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && ptr_reg[1:0] == 2'd1) |-> rd_data == out_reg);

  assert_idle_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |-> rd_data == '0);
endmodule

bind pin_expander pin_expander_chk #(.NPIN(NPIN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_evt  (bus_evt),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .rd_req   (rd_req),
  .rd_data  (rd_data),
  .pin_level(pin_level),
  .ptr_reg  (ptr_reg),
  .have_ptr (have_ptr),
  .out_reg  (out_reg),
  .pol_reg  (pol_reg),
  .dir_reg  (dir_reg)
);

// File: tb/pin_expander_bench.sv
`timescale 1ns/1ps
module pin_expander_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_evt = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] rx_data = '0;
  logic       rd_req = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] ext_level = 8'hFF;
  logic [7:0] pin_level;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pin_expander u_pin_expander (
    .clk(clk), .rst_n(rst_n), .bus_evt(bus_evt), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rd_req(rd_req), .rd_data(rd_data),
    .ext_level(ext_level), .pin_level(pin_level)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic event_pulse();
    @(negedge clk);
    bus_evt = 1'b1;
    @(negedge clk);
    bus_evt = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [7:0] exp);
    rd_req = 1'b1;
    #0.5;
    check(req, rd_data, exp);
    rd_req = 1'b0;
  endtask

  task automatic select(input logic [7:0] p);
    event_pulse();
    send(p);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 pin_level", pin_level, 8'hFF);
    check("R1 rx_ready", {7'd0, rx_ready}, 8'h01);
    check("R5 idle rd_data", rd_data, 8'h00);
    read_chk("R1 input", 8'hFF);
    select(8'h01); read_chk("R1 output", 8'hFF);
    select(8'h02); read_chk("R1 polarity", 8'h00);
    select(8'h03); read_chk("R1 direction", 8'hFF);
  endtask

  task automatic t_drive();
    select(8'h03); send(8'hF0);
    select(8'h01); send(8'hA5);
    @(negedge clk);
    check("R7 drive low", pin_level, 8'hF5);
    send(8'h5A);
    @(negedge clk);
    check("R3 second data byte", pin_level, 8'hFA);
    read_chk("R3 pointer holds", 8'h5A);
  endtask

  task automatic t_polarity();
    select(8'h02); send(8'h0F);
    @(negedge clk);
    check("R10 polarity no pin effect", pin_level, 8'hFA);
    select(8'h00);
    read_chk("R5 input xor polarity", 8'hF5);
  endtask

  task automatic t_external();
    @(negedge clk);
    ext_level = 8'h7F;
    @(negedge clk); @(negedge clk);
    check("R8 ext after two edges", pin_level, 8'hFA);
    @(negedge clk);
    check("R8 ext after three edges", pin_level, 8'h7A);
    check("R9 pin equals input", pin_level, 8'h7A);
    read_chk("R5 input read", 8'h75);
  endtask

  task automatic t_input_write();
    send(8'h00);
    @(negedge clk);
    check("R6 pin unchanged", pin_level, 8'h7A);
    read_chk("R6 input read unchanged", 8'h75);
    select(8'h01); read_chk("R6 output unchanged", 8'h5A);
    select(8'h03); read_chk("R6 direction unchanged", 8'hF0);
  endtask

  task automatic t_high_ptr();
    select(8'hFD);
    read_chk("R2 high bits ignored", 8'h5A);
    send(8'h33);
    @(negedge clk);
    check("R2 write via aliased pointer", pin_level, 8'h73);
  endtask

  task automatic t_event();
    select(8'h22);
    read_chk("R4 new pointer after event", 8'h0F);
    @(negedge clk);
    bus_evt = 1'b1; rx_valid = 1'b1; rx_data = 8'h03;
    #0.5;
    check("R4 ready low in event", {7'd0, rx_ready}, 8'h00);
    @(negedge clk);
    bus_evt = 1'b0; rx_valid = 1'b0;
    send(8'h01);
    read_chk("R4 colliding byte dropped", 8'h33);
  endtask

  task automatic t_timing();
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'hFF;
    @(negedge clk);
    rx_valid = 1'b0;
    read_chk("R8 register visible next cycle", 8'hFF);
    check("R8 pin not yet recomputed", pin_level, 8'h73);
    @(negedge clk);
    check("R8 pin recomputed", pin_level, 8'h7F);
    ext_level = 8'hFF;
    repeat (3) @(negedge clk);
    check("R9 pin released", pin_level, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_drive();
    t_polarity();
    t_external();
    t_input_write();
    t_high_ptr();
    t_event();
    t_timing();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule